// File: doc/BRIEF.md
# Switchable-Order Sinc Decimator

This block turns a one-bit sigma-delta modulator stream into signed multi-bit conversion results. Each accepted modulator bit is mapped to +1 or -1 and passed through a cascaded integrator-comb structure. The structure decimates by a programmable ratio R = BASE_DEC × FS, where FS is an unsigned rate word. A single select bit chooses between a fourth-order sinc response, which is the reset default, and a third-order sinc response. Both orders use the same ratio, so the notch frequencies do not move when the order changes.

A system uses it behind a modulator clocked from the master clock. The sample strobe marks each modulator bit. The restart input is pulsed whenever the analog input channel is switched. A restart pulse, or any change of the order bit or the rate word, clears the filter and the decimation count. After that, results are held back until the filter window holds only new samples. That is the third decimated output for the third-order filter and the fourth for the fourth-order filter.

Top module: `sinc_decim`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, result_valid is 0 and result is 0.
- R2: order_sel = 0 selects the fourth-order response (N = 4) and order_sel = 1 selects the third-order response (N = 3). Once settled, a constant input of ones yields result = +R^N and a constant input of zeros yields result = -R^N. Both values are taken as the top OUT_W bits of the ACC_W-bit sum, where ACC_W = 4·clog2(BASE_DEC·(2^RATE_W−1)) + 1.
- R3: The decimation ratio R is BASE_DEC × FS accepted samples, so a decimated output occurs on every R-th accepted sample. A rate word of 0 behaves as FS = 1.
- R4: After a restart, the first result_valid is raised on the N-th decimated output, that is after exactly N·R accepted samples. The earlier outputs are suppressed.
- R5: Bit value 1 counts as +1 and bit value 0 counts as -1. The settled result equals Σ h[d]·x[n−d] over d = 0 … N(R−1), with two's-complement arithmetic. Here h is the R-long boxcar convolved with itself N times, x[n] is the newest accepted sample, and samples from before the restart count as 0.
- R6: A restart pulse clears all filter state and the settling count. A sample strobed in the same cycle as the pulse is discarded.
- R7: A change of order_sel or rate_word from its value in the previous cycle acts exactly as a restart pulse in that cycle.
- R8: result_valid is high for one cycle per result. result keeps its value in every cycle in which result_valid is low, including across restarts.
- R9: mod_bit has no effect in cycles where sample_stb is low. Those cycles neither advance the filter nor count toward R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | One-cycle pulse that clears the filter (channel switch) |
| sample_stb | input | 1 | High in cycles carrying a modulator bit |
| mod_bit | input | 1 | Modulator output bit (1 → +1, 0 → −1) |
| order_sel | input | 1 | 0: fourth-order sinc, 1: third-order sinc |
| rate_word | input | RATE_W | Rate word FS; the ratio is BASE_DEC × FS |
| result | output | OUT_W | Signed decimated result, held between strobes |
| result_valid | output | 1 | One-cycle strobe for each settled result |

## Verification
The bench sweeps both orders against several rate words, including the zero word, in a reduced configuration whose accumulator output is exact. Constant streams of ones and of zeros pin the full-scale gain ±R^N, which tells the two orders and the ratios apart. An alternating stream and a pseudo-random stream are compared sample by sample with a sinc^N convolution computed in the bench. These two streams expose kernel alignment and wraparound faults that constant inputs would hide. The pseudo-random stream also leaves idle cycles with a toggling bit, and the runs alternate between restart pulses, pure configuration changes and uninterrupted continuation, so that both the settling gate and the ignored-cycle behaviour are checked.

// File: rtl/sinc_decim_pkg.sv
// Shared definitions for the switchable-order sinc decimator.
package sinc_decim_pkg;
    // Number of integrator/comb stages built (highest order supported).
    localparam int STAGES_MAX = 4;
    // Order used when the low-order response is selected.
    localparam int ORDER_LOW  = 3;

    // Encoding of the order select input.
    typedef enum logic {
        ORD_SINC4 = 1'b0,
        ORD_SINC3 = 1'b1
    } order_e;
endpackage

// File: rtl/sinc_integrators.sv
// Integrator chain of the CIC filter.
// Holds STAGES accumulators that are chained without pipeline delay, so the
// next value of stage i already includes the new sample. Assumes wraparound
// two's-complement arithmetic is acceptable (the comb section undoes it).
module sinc_integrators #(
    parameter int ACC_W  = 21,
    parameter int STAGES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           stb,
    input  logic                           din_bit,
    output logic [STAGES-1:0][ACC_W-1:0]   acc_next
);
    logic [STAGES-1:0][ACC_W-1:0] acc_q;
    logic [ACC_W-1:0]             x_in;

    // Map the modulator bit to +1 / -1.
    assign x_in = din_bit ? ACC_W'(1) : {ACC_W{1'b1}};

    // Combinational cascade of next-state sums.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign acc_next[i] = acc_q[i] + x_in;
        end else begin : g_rest
            assign acc_next[i] = acc_q[i] + acc_next[i-1];
        end
    end

    // Accumulator registers: cleared on reset or restart, advanced per sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (stb) begin
            acc_q <= acc_next;
        end
    end
endmodule

// File: rtl/sinc_combs.sv
// Comb (differentiator) chain of the CIC filter, run at the decimated rate.
// Each stage subtracts its input from the previous decimated tick. When the
// low order is selected the last stage is bypassed; the caller feeds the
// matching integrator output. Assumes a clear whenever the order changes.
module sinc_combs #(
    parameter int ACC_W     = 21,
    parameter int STAGES    = 4,
    parameter int ORDER_LOW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             low_order,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    logic [ACC_W-1:0] dly_q  [STAGES];
    logic [ACC_W-1:0] st_in  [STAGES];
    logic [ACC_W-1:0] st_out [STAGES];

    // Cascade of differences against the stored previous-tick values.
    for (genvar j = 0; j < STAGES; j++) begin : g_comb
        if (j == 0) begin : g_head
            assign st_in[j] = din;
        end else begin : g_tail
            assign st_in[j] = st_out[j-1];
        end
        assign st_out[j] = st_in[j] - dly_q[j];

        // Delay register: captures the stage input on each decimated tick.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                dly_q[j] <= '0;
            end else if (tick) begin
                dly_q[j] <= st_in[j];
            end
        end
    end

    // Output tap chosen by the active order.
    assign dout = low_order ? st_out[ORDER_LOW-1] : st_out[STAGES-1];
endmodule

// File: rtl/sinc_sequencer.sv
// Decimation counter and settling gate.
// Counts accepted samples up to R = BASE_DEC * FS (FS = 0 treated as 1),
// raises tick on the R-th sample and emit on ticks once the active order's
// number of ticks since the last clear has been reached. Assumes BASE_DEC is
// a power of two.
module sinc_sequencer #(
    parameter int BASE_DEC = 4,
    parameter int RATE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              stb,
    input  logic              low_order,
    input  logic [RATE_W-1:0] fs,
    output logic              tick,
    output logic              emit
);
    localparam int BASE_LG = $clog2(BASE_DEC);
    localparam int CNT_W   = RATE_W + BASE_LG;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  last_idx;
    logic [RATE_W-1:0] fs_eff;
    logic [2:0]        ticks_q;
    logic [2:0]        need;

    // Effective rate word and index of the last sample in a period.
    assign fs_eff   = (fs == '0) ? RATE_W'(1) : fs;
    assign last_idx = (CNT_W'(fs_eff) << BASE_LG) - CNT_W'(1);
    assign tick     = stb && (cnt_q == last_idx);
    assign need     = low_order ? 3'd2 : 3'd3;
    assign emit     = tick && (ticks_q >= need);

    // Sample counter within one decimation period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (stb) begin
            cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Saturating count of decimated ticks since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ticks_q <= '0;
        end else if (tick && ticks_q != 3'd4) begin
            ticks_q <= ticks_q + 3'd1;
        end
    end
endmodule

// File: rtl/sinc_decim.sv
// Top of the switchable-order sinc decimator.
// Detects restarts (pulse or configuration change), drives the integrator,
// comb and sequencer blocks and registers the truncated result. Assumes
// OUT_W <= ACC_W and BASE_DEC a power of two.
module sinc_decim
    import sinc_decim_pkg::*;
#(
    parameter int BASE_DEC = 1024,
    parameter int RATE_W   = 10,
    parameter int OUT_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              sample_stb,
    input  logic              mod_bit,
    input  logic              order_sel,
    input  logic [RATE_W-1:0] rate_word,
    output logic [OUT_W-1:0]  result,
    output logic              result_valid
);
    localparam int RATIO_MAX = BASE_DEC * ((1 << RATE_W) - 1);
    localparam int ACC_W     = STAGES_MAX * $clog2(RATIO_MAX) + 1;

    order_e                          order_q;
    logic [RATE_W-1:0]               rate_q;
    logic                            clear;
    logic                            stb_eff;
    logic                            low_order;
    logic                            tick;
    logic                            emit;
    logic [STAGES_MAX-1:0][ACC_W-1:0] acc_next;
    logic [ACC_W-1:0]                comb_in;
    logic [ACC_W-1:0]                comb_out;

    // Restart on a pulse or on any change of the configuration inputs.
    assign clear     = restart || (order_e'(order_sel) != order_q) || (rate_word != rate_q);
    assign stb_eff   = sample_stb && !clear;
    assign low_order = (order_q == ORD_SINC3);
    assign comb_in   = low_order ? acc_next[ORDER_LOW-1] : acc_next[STAGES_MAX-1];

    // Configuration shadow used to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= ORD_SINC4;
            rate_q  <= RATE_W'(1);
        end else begin
            order_q <= order_e'(order_sel);
            rate_q  <= rate_word;
        end
    end

    sinc_integrators #(
        .ACC_W  (ACC_W),
        .STAGES (STAGES_MAX)
    ) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .stb      (stb_eff),
        .din_bit  (mod_bit),
        .acc_next (acc_next)
    );

    sinc_combs #(
        .ACC_W     (ACC_W),
        .STAGES    (STAGES_MAX),
        .ORDER_LOW (ORDER_LOW)
    ) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .tick      (tick),
        .low_order (low_order),
        .din       (comb_in),
        .dout      (comb_out)
    );

    sinc_sequencer #(
        .BASE_DEC (BASE_DEC),
        .RATE_W   (RATE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .stb       (stb_eff),
        .low_order (low_order),
        .fs        (rate_q),
        .tick      (tick),
        .emit      (emit)
    );

    // Output register: capture the top bits on each settled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= emit;
            if (emit) begin
                result <= comb_out[ACC_W-1 -: OUT_W];
            end
        end
    end
endmodule

// File: rtl/sinc_decim_chk.sv
// Property checker for sinc_decim, attached by bind. Observes only ports and
// keeps its own copies of configuration and sample counts.
module sinc_decim_chk #(
    parameter int BASE_DEC = 1024,
    parameter int RATE_W   = 10,
    parameter int OUT_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              sample_stb,
    input logic              order_sel,
    input logic [RATE_W-1:0] rate_word,
    input logic [OUT_W-1:0]  result,
    input logic              result_valid
);
    logic              ord_c;
    logic [RATE_W-1:0] rate_c;
    logic              rst_seen_low;
    logic              first_pending;
    logic [31:0]       nsamp;
    logic              restart_eq;
    int unsigned       ratio_c;

    assign restart_eq = restart || (order_sel != ord_c) || (rate_word != rate_c);
    assign ratio_c    = BASE_DEC * ((rate_c == '0) ? 1 : int'(rate_c));

    // Independent tracking of configuration, samples and first-result state.
    always_ff @(posedge clk) begin
        rst_seen_low <= !rst_n;
        if (!rst_n) begin
            ord_c         <= 1'b0;
            rate_c        <= RATE_W'(1);
            nsamp         <= '0;
            first_pending <= 1'b1;
        end else begin
            ord_c  <= order_sel;
            rate_c <= rate_word;
            if (restart_eq) begin
                nsamp         <= '0;
                first_pending <= 1'b1;
            end else begin
                if (sample_stb) nsamp <= nsamp + 32'd1;
                if (result_valid) first_pending <= 1'b0;
            end
        end
    end

    // R1: reset state
    always_ff @(posedge clk) begin
        if (rst_seen_low === 1'b1) begin
            assert_reset_state_R1: assert (!result_valid && result == '0);
        end
    end

    assert_from_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(sample_stb));

    assert_first_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && first_pending) |->
            (nsamp == (ord_c ? 32'd3 : 32'd4) * ratio_c));

    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !result_valid);

    assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((order_sel != ord_c) || (rate_word != rate_c)) |=> !result_valid);

    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));
endmodule

bind sinc_decim sinc_decim_chk #(
    .BASE_DEC (BASE_DEC),
    .RATE_W   (RATE_W),
    .OUT_W    (OUT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .sample_stb   (sample_stb),
    .order_sel    (order_sel),
    .rate_word    (rate_word),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/sinc_decim_tb.sv
// Sweep bench for sinc_decim in a small exact configuration.
module sinc_decim_tb;
    localparam int BASE_DEC = 4;
    localparam int RATE_W   = 3;
    localparam int ACC_W    = 4 * $clog2(BASE_DEC * ((1 << RATE_W) - 1)) + 1;
    localparam int OUT_W    = ACC_W;
    localparam int MAXS     = 4096;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              restart;
    logic              sample_stb;
    logic              mod_bit;
    logic              order_sel;
    logic [RATE_W-1:0] rate_word;
    logic [OUT_W-1:0]  result;
    logic              result_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    int     x [MAXS];
    int     hk [512];
    int     hlen;
    int     n_s;
    int     k_t;
    int     m_ord;
    int     m_rate;
    bit     exp_valid;
    longint exp_res;
    longint last_res;
    bit     have_last;
    string  kind;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    sinc_decim #(
        .BASE_DEC (BASE_DEC),
        .RATE_W   (RATE_W),
        .OUT_W    (OUT_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .sample_stb   (sample_stb),
        .mod_bit      (mod_bit),
        .order_sel    (order_sel),
        .rate_word    (rate_word),
        .result       (result),
        .result_valid (result_valid)
    );

    function automatic int ratio_of(int fs);
        return BASE_DEC * ((fs == 0) ? 1 : fs);
    endfunction

    // Kernel of sinc^N: boxcar of length R convolved N times.
    task automatic build_kernel(int nord, int r);
        int tmp [512];
        hk[0] = 1;
        hlen  = 1;
        for (int s = 0; s < nord; s++) begin
            for (int i = 0; i < hlen + r - 1; i++) begin
                tmp[i] = 0;
                for (int j = 0; j < r; j++)
                    if (i - j >= 0 && i - j < hlen) tmp[i] += hk[i-j];
            end
            hlen = hlen + r - 1;
            for (int i = 0; i < hlen; i++) hk[i] = tmp[i];
        end
    endtask

    // One cycle: drive inputs, advance the model, check after the edge.
    task automatic step(bit stb, bit b, bit pulse, int ord, int fs, string rtag);
        bit     restart_eq;
        int     nord;
        int     r;
        @(negedge clk);
        restart    = pulse;
        sample_stb = stb;
        mod_bit    = b;
        order_sel  = ord[0];
        rate_word  = RATE_W'(fs);
        restart_eq = pulse || (ord != m_ord) || (fs != m_rate);
        m_ord  = ord;
        m_rate = fs;
        nord   = (ord == 1) ? 3 : 4;
        r      = ratio_of(fs);
        exp_valid = 0;
        if (restart_eq) begin
            n_s = 0;
            k_t = 0;
            build_kernel(nord, r);
        end else if (stb) begin
            n_s++;
            x[n_s] = b ? 1 : -1;
            if (n_s % r == 0) begin
                k_t++;
                if (k_t >= nord) begin
                    exp_valid = 1;
                    exp_res   = 0;
                    for (int d = 0; d < hlen; d++)
                        if (n_s - d >= 1) exp_res += longint'(hk[d]) * x[n_s-d];
                end
            end
        end
        @(posedge clk);
        #1;
        if (result_valid !== exp_valid) begin
            errors++;
            checks++;
            $display("FAIL R3/R4 (%s) valid timing: actual %0b expected %0b", kind, result_valid, exp_valid);
        end
        if (exp_valid) begin
            checks++;
            if ($signed(result) != exp_res) begin
                errors++;
                $display("FAIL %s result: actual %0d expected %0d", rtag, $signed(result), exp_res);
            end
            last_res  = exp_res;
            have_last = 1;
        end else if (have_last) begin
            checks++;
            if ($signed(result) != last_res) begin
                errors++;
                $display("FAIL R8 hold: actual %0d expected %0d", $signed(result), last_res);
            end
        end
    endtask

    // One run: apply config (pulse optional), then feed a pattern until
    // three results have been produced.
    task automatic run(int ord, int fs, int pat, bit pulse);
        int    got;
        int    idx;
        string rtag;
        bit    b;
        bit    stb;
        // R2 constant streams, R5 alternating and random, R9 with idle gaps
        rtag = (pat < 2) ? "R2" : (pat == 2) ? "R5" : "R9";
        kind = pulse ? "R6" : ((ord != m_ord || fs != m_rate) ? "R7" : "R4");
        // The first cycle carries a strobe that must be discarded on a restart (R6).
        step(1'b1, 1'b1, pulse, ord, fs, rtag);
        got = 0;
        idx = 0;
        while (got < 3 && idx < 2000) begin
            idx++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            stb  = 1'b1;
            case (pat)
                0:       b = 1'b1;
                1:       b = 1'b0;
                2:       b = idx[0];
                default: begin
                    b   = lfsr[0];
                    stb = (idx % 3 != 0);
                end
            endcase
            step(stb, b, 1'b0, ord, fs, rtag);
            if (exp_valid) got++;
        end
        checks++;
        if (got < 3) begin
            errors++;
            $display("FAIL R3 run produced %0d results, expected 3", got);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int fs_list [4] = '{0, 1, 2, 7};
        rst_n      = 1'b0;
        restart    = 1'b0;
        sample_stb = 1'b0;
        mod_bit    = 1'b0;
        order_sel  = 1'b0;
        rate_word  = RATE_W'(1);
        m_ord      = 0;
        m_rate     = 1;
        n_s        = 0;
        k_t        = 0;
        have_last  = 0;
        build_kernel(4, ratio_of(1));
        repeat (4) @(posedge clk);
        #1;
        // R1: during reset
        checks++;
        if (result_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R1 in reset: valid %0b result %0d expected 0 0", result_valid, result);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: first cycle after release
        checks++;
        if (result_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R1 after release: valid %0b result %0d expected 0 0", result_valid, result);
        end
        // Sweep: R2 order select, R3 ratios incl. zero word, R6 pulses, R7 config changes
        for (int o = 0; o < 2; o++)
            for (int f = 0; f < 4; f++)
                for (int p = 0; p < 4; p++)
                    run(o, fs_list[f], p, p == 2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule